// File: doc/BRIEF.md
# Single-Slope Converter Digital Back End

This block is the digital half of a per-pixel single-slope analog-to-digital converter. After a conversion is requested it waits a fixed settling offset, then opens a ramp window of exactly 2^CW clock cycles. During that window, and only then, a binary counter advances once per cycle. Its value is published in reflected Gray code, so that a single bit moves at each step. A comparator-driven enable from the analog side decides which count values reach a one-word pixel store: on every ramp cycle with the enable high, the store takes the present Gray value. The word left in the store when the ramp ends is the code for the instant at which the ramp crossed the pixel voltage.

Readout starts on the cycle after the ramp window closes and lasts READ_LEN x ROWS cycles. The first readout cycle clears the counter for the next frame. It also loads a registered Gray-to-binary conversion of the stored word, which is then announced by a one-cycle valid pulse. If the comparator enable is still high on the final ramp cycle, the input never crossed the ramp, and an overflow flag is raised alongside the full-scale result. The frame controller then returns to idle and waits for the next start request.

Top module: `ss_adc_backend`

## Requirements
- R1: On ramp cycle j (j = 0 for the first cycle with `ramp_o` high), `gray_o` equals j XOR (j >> 1), so consecutive ramp cycles differ in exactly one bit.
- R2: A start request sampled high in idle is followed by exactly START_DLY non-ramp cycles and then by exactly 2^CW consecutive cycles with `ramp_o` high.
- R3: The count does not advance outside the ramp window. It holds 2^CW-1 (Gray 0x80 for CW=8) during the first readout cycle and is 0 from the second readout cycle on. It is 0 after reset.
- R4: On each ramp cycle with `cmp_en_i` high, the store takes that cycle's `gray_o`, visible on `store_o` one cycle later. The store holds its value otherwise, so the last enabled ramp cycle wins. `cmp_en_i` outside the ramp window has no effect on `store_o`.
- R5: The store and the overflow flag clear when a start request is accepted. A frame with no enabled ramp cycle yields `store_o` = 0 and `bin_o` = 0. Reset clears all outputs.
- R6: `read_o` rises on the cycle after the last ramp cycle, stays high for exactly READ_LEN x ROWS cycles, and never overlaps `ramp_o`.
- R7: `bin_o` is the binary form of the stored Gray word: bit i (bit 0 least significant) is the XOR of Gray bits CW-1 down to i. The result for a capture on ramp cycle j is therefore j.
- R8: `valid_o` is a single-cycle pulse on the second readout cycle. `bin_o` is updated at the same time and holds its value until the next frame's readout.
- R9: `ovf_o` is 1 from the first readout cycle exactly when `cmp_en_i` was high on the last ramp cycle. In that case `bin_o` = 2^CW-1.
- R10: A start request made while a frame is in progress is ignored and changes no frame timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled in idle |
| cmp_en_i | input | 1 | Comparator enable; high while the ramp is below the pixel input |
| gray_o | output | CW | Counter value in Gray code |
| store_o | output | CW | Stored Gray word of the pixel |
| bin_o | output | CW | Registered binary result |
| valid_o | output | 1 | One-cycle pulse marking a new `bin_o` |
| ovf_o | output | 1 | Comparator never dropped during the ramp |
| ramp_o | output | 1 | Ramp window active (counter enabled) |
| read_o | output | 1 | Readout phase active |

## Verification
The assertions check the following on every cycle:
- the single-bit Gray step while counting;
- counter, store, overflow and result holding when not written;
- the store tracking the count when enabled;
- the length of the delay and the readout phases;
- the valid pulse width;
- full-scale result under overflow.

Only the bench's scenarios can show that the captured code equals the index of the last enabled ramp cycle for every one of the 256 crossing points. The same holds for these properties:
- a comparator that re-rises after dropping moves the result;
- a frame with no enable gives zero;
- stray comparator and start activity outside the ramp leaves the result and the frame timing untouched.

// File: rtl/ss_adc_pkg.sv
package ss_adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RAMP  = 2'd2,
    ST_READ  = 2'd3
  } frame_st_e;

  // reflected Gray code of a binary value (callers truncate to their width)
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/ssa_frame_ctrl.sv
module ssa_frame_ctrl
  import ss_adc_pkg::*;
#(
  parameter int START_DLY = 4,
  parameter int RD_CYC    = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cnt_full_i,
  output logic ramp_o,
  output logic read_o,
  output logic frame_go_o,
  output logic rd_first_o
);

  localparam int MAXT = (START_DLY > RD_CYC) ? START_DLY : RD_CYC;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] DLY_LAST = TW'((START_DLY > 0) ? START_DLY - 1 : 0);
  localparam logic [TW-1:0] RD_LAST  = TW'(RD_CYC - 1);

  frame_st_e       state_q, state_d, arm_st;
  logic [TW-1:0]   tmr_q, tmr_d;

  // the state entered when a request is accepted depends on the offset
  generate
    if (START_DLY == 0) begin : g_no_dly
      assign arm_st = ST_RAMP;
    end else begin : g_dly
      assign arm_st = ST_DELAY;
    end
  endgenerate

  always_comb begin
    state_d    = state_q;
    tmr_d      = tmr_q;
    frame_go_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          frame_go_o = 1'b1;
          tmr_d      = '0;
          state_d    = arm_st;
        end
      end
      ST_DELAY: begin
        if (tmr_q == DLY_LAST) begin
          tmr_d   = '0;
          state_d = ST_RAMP;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      ST_RAMP: begin
        if (cnt_full_i) begin
          tmr_d   = '0;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (tmr_q == RD_LAST) begin
          tmr_d   = '0;
          state_d = ST_IDLE;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
    end
  end

  assign ramp_o     = (state_q == ST_RAMP);
  assign read_o     = (state_q == ST_READ);
  assign rd_first_o = read_o && (tmr_q == '0);

  AST_RAMP_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_o && cnt_full_i) |=> (read_o && rd_first_o)); // R6
  AST_READ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (read_o && tmr_q != RD_LAST) |=> read_o); // R6
  AST_DELAY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DELAY && tmr_q != DLY_LAST) |=> (state_q == ST_DELAY)); // R2

endmodule

// File: rtl/ssa_gray_counter.sv
module ssa_gray_counter
  import ss_adc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          clr_i,
  output logic [CW-1:0] gray_o,
  output logic          full_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign gray_o = CW'(to_gray(32'(cnt_q)));
  assign full_o = &cnt_q;

  AST_GRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i) |=> ($countones(gray_o ^ $past(gray_o)) == 1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(gray_o)); // R3

endmodule

// File: rtl/ssa_pixel_store.sv
module ssa_pixel_store #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic          last_i,
  input  logic [CW-1:0] gray_i,
  output logic [CW-1:0] store_o,
  output logic          ovf_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_o <= '0;
      ovf_o   <= 1'b0;
    end else if (clr_i) begin
      store_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      if (wr_i)   store_o <= gray_i;
      if (last_i) ovf_o   <= wr_i;
    end
  end

  AST_STORE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clr_i) |=> (store_o == $past(gray_i))); // R4
  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !clr_i) |=> $stable(store_o)); // R4
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !last_i) |=> $stable(ovf_o)); // R9

endmodule

// File: rtl/ssa_readout.sv
module ssa_readout #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_i,
  input  logic [CW-1:0] gray_i,
  output logic [CW-1:0] bin_o,
  output logic          valid_o
);

  logic [CW-1:0] bin_c;

  // each binary bit is the parity of the Gray bits at and above it
  generate
    for (genvar i = 0; i < CW; i++) begin : g_bit
      assign bin_c[i] = ^gray_i[CW-1:i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= latch_i;
      if (latch_i) bin_o <= bin_c;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R8
  AST_BIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> $stable(bin_o)); // R8

endmodule

// File: rtl/ss_adc_backend.sv
module ss_adc_backend #(
  parameter int CW        = 8,
  parameter int START_DLY = 4,
  parameter int READ_LEN  = 20,
  parameter int ROWS      = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmp_en_i,
  output logic [CW-1:0] gray_o,
  output logic [CW-1:0] store_o,
  output logic [CW-1:0] bin_o,
  output logic          valid_o,
  output logic          ovf_o,
  output logic          ramp_o,
  output logic          read_o
);

  localparam int RD_CYC = READ_LEN * ROWS;

  // named internal events
  logic cnt_full;
  logic frame_go;
  logic rd_first;
  logic cnt_en;
  logic store_wr;
  logic ramp_last;

  assign cnt_en    = ramp_o && !cnt_full;
  assign store_wr  = ramp_o && cmp_en_i;
  assign ramp_last = ramp_o && cnt_full;

  ssa_frame_ctrl #(.START_DLY(START_DLY), .RD_CYC(RD_CYC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cnt_full_i (cnt_full),
    .ramp_o     (ramp_o),
    .read_o     (read_o),
    .frame_go_o (frame_go),
    .rd_first_o (rd_first)
  );

  ssa_gray_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (cnt_en),
    .clr_i  (rd_first),
    .gray_o (gray_o),
    .full_o (cnt_full)
  );

  ssa_pixel_store #(.CW(CW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (frame_go),
    .wr_i    (store_wr),
    .last_i  (ramp_last),
    .gray_i  (gray_o),
    .store_o (store_o),
    .ovf_o   (ovf_o)
  );

  ssa_readout #(.CW(CW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .latch_i (rd_first),
    .gray_i  (store_o),
    .bin_o   (bin_o),
    .valid_o (valid_o)
  );

  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ovf_o) |-> (bin_o == {CW{1'b1}})); // R9
  AST_RAMP_FALL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ramp_o) |-> read_o); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramp_o && read_o)); // R6

endmodule

// File: tb/tb_ss_adc_backend.sv
`timescale 1ns/1ps
module tb_ss_adc_backend;

  localparam int CW        = 8;
  localparam int START_DLY = 4;
  localparam int READ_LEN  = 20;
  localparam int ROWS      = 1;
  localparam int RD_CYC    = READ_LEN * ROWS;
  localparam int NRAMP     = 1 << CW;
  localparam int WD_LIMIT  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cmp_en_i = 1'b0;
  logic [CW-1:0] gray_o, store_o, bin_o;
  logic valid_o, ovf_o, ramp_o, read_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_store = 0;
  int last_bin = 0;

  always #2 clk = ~clk;

  ss_adc_backend #(.CW(CW), .START_DLY(START_DLY), .READ_LEN(READ_LEN), .ROWS(ROWS)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_en_i(cmp_en_i),
    .gray_o(gray_o), .store_o(store_o), .bin_o(bin_o), .valid_o(valid_o),
    .ovf_o(ovf_o), .ramp_o(ramp_o), .read_o(read_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not end, act=%0d exp<%0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int gcode(input int v);
    return v ^ (v >> 1);
  endfunction

  // one frame: comparator high on ramp cycles in [a0,a1] or [b0,b1]
  task automatic run_frame(input int a0, input int a1, input int b0, input int b1, input bit noise);
    int expi = -1;
    int exp_g, exp_b, d, j, r;
    bit exp_ovf;
    for (int k = 0; k < NRAMP; k++)
      if ((k >= a0 && k <= a1) || (k >= b0 && k <= b1)) expi = k;
    exp_g   = (expi < 0) ? 0 : gcode(expi);
    exp_b   = (expi < 0) ? 0 : expi;
    exp_ovf = (expi == NRAMP - 1);

    if (noise) begin
      cmp_en_i = 1'b1;
      repeat (3) @(negedge clk);
      chk(store_o == last_store, "R4 idle comparator ignored", store_o, last_store);
      chk(bin_o == last_bin, "R8 result held in idle", bin_o, last_bin);
      cmp_en_i = 1'b0;
    end

    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(store_o == 0, "R5 store cleared at start", store_o, 0);
    chk(ovf_o == 1'b0, "R5 overflow cleared at start", ovf_o, 0);
    d = 0;
    while (!ramp_o && d < 100) begin
      d++;
      @(negedge clk);
    end
    chk(d == START_DLY, "R2 start offset", d, START_DLY);

    j = 0;
    while (ramp_o && j < NRAMP + 10) begin
      chk(gray_o == gcode(j), "R1 gray count", gray_o, gcode(j));
      chk(read_o == 1'b0, "R6 no overlap", read_o, 0);
      cmp_en_i = ((j >= a0 && j <= a1) || (j >= b0 && j <= b1));
      start_i  = noise && (j == 100);   // R10 request during ramp
      j++;
      @(negedge clk);
    end
    start_i  = 1'b0;
    cmp_en_i = noise;
    chk(j == NRAMP, "R2 ramp length", j, NRAMP);

    r = 0;
    while (read_o && r < RD_CYC + 10) begin
      if (r == 0) begin
        chk(gray_o == gcode(NRAMP - 1), "R3 count frozen at readout", gray_o, gcode(NRAMP - 1));
        chk(ovf_o == exp_ovf, "R9 overflow flag", ovf_o, exp_ovf);
      end else begin
        chk(gray_o == 0, "R3 count cleared in readout", gray_o, 0);
      end
      if (r == 1) begin
        chk(valid_o == 1'b1, "R8 valid pulse", valid_o, 1);
        chk(bin_o == exp_b, "R7 binary result", bin_o, exp_b);
        chk(store_o == exp_g, "R4 stored gray", store_o, exp_g);
      end else begin
        chk(valid_o == 1'b0, "R8 valid single cycle", valid_o, 0);
      end
      r++;
      @(negedge clk);
    end
    cmp_en_i = 1'b0;
    chk(r == RD_CYC, "R6 readout length", r, RD_CYC);
    chk(ramp_o == 1'b0, "R10 no new ramp after readout", ramp_o, 0);
    chk(store_o == exp_g, "R4 store held through readout", store_o, exp_g);
    chk(bin_o == exp_b, "R8 result held", bin_o, exp_b);
    if (exp_ovf) chk(bin_o == NRAMP - 1, "R9 full scale", bin_o, NRAMP - 1);
    if (expi < 0) chk(bin_o == 0, "R5 no enable gives zero", bin_o, 0);
    last_store = exp_g;
    last_bin   = exp_b;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gray_o == 0, "R3 reset count", gray_o, 0);
    chk(store_o == 0, "R5 reset store", store_o, 0);
    chk(bin_o == 0, "R5 reset result", bin_o, 0);
    chk(valid_o == 0, "R8 reset valid", valid_o, 0);
    chk({ovf_o, ramp_o, read_o} == 3'b000, "R6 reset phases", {ovf_o, ramp_o, read_o}, 0);

    // sweep every crossing point
    for (int k = 0; k < NRAMP; k++) run_frame(0, k, 1, 0, 1'b0);
    // no enable at all
    run_frame(1, 0, 1, 0, 1'b1);
    // comparator drops, then re-rises: last enabled cycle wins
    run_frame(0, 50, 100, 120, 1'b1);
    // enable starts late and runs to the end: overflow
    run_frame(200, NRAMP - 1, 1, 0, 1'b1);
    // single enabled cycle mid-ramp
    run_frame(77, 77, 1, 0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule